// File: doc/BRIEF.md
# Isolated Link Framer With Failure Shutdown

This block carries a word of channel enables from one side of an isolation barrier to the other over a single serial line. The sending half turns the current enable word into a fixed-length frame. It sends a frame once per transmission period. It also sends one at once when the word changes, provided no frame is on the line at that moment.

The receiving half shifts each frame in and judges it before using it. Only a frame that passes updates the output enable register. A single bad frame leaves the last good state in place. Repeated bad frames, or a line that stays silent, force every channel off and raise a link-fault flag. The first good frame after that restores normal operation.

In a system, `line_o` drives the barrier coder and `line_i` receives the decoded bit stream from the far side. Each line bit lasts one clock cycle. Both halves are in one top module so they can share a parameter set. Their only contact is through the serial line.

Top module: `iso_link_framer`

## Requirements
- R1: The serial line idles at 1. A frame is 12 bits, sent one bit per cycle. Bit 0 is 0 and bit 1 is 1; together they form the start marker. Bits 2 to 9 carry the data, least significant bit first. Bit 10 is the sequence toggle. Bit 11 is a parity bit that makes the count of ones in bits 2 to 11 even.
- R2: While the transmit word is unchanged, a new frame starts every PERIOD_CYCLES cycles (178 by default).
- R3: A change of `tx_word_i` while no frame is being sent starts a frame on the next clock edge.
- R4: The sequence toggle bit inverts from each frame to the next.
- R5: A change made while a frame is being sent does not cut that frame short. The next frame follows after exactly one idle cycle and carries the newer word.
- R6: A valid frame sets `rx_word_o` to its data. In loopback, a write reaches `rx_word_o` 14 clock edges after the edge at which the write is seen, and not earlier.
- R7: The receiver rejects three kinds of frame, and none of them changes `rx_word_o` on its own: a frame whose bit 1 is 0 (bad marker), a frame with odd parity over bits 2 to 11, and a frame whose line is not idle in the cycle after bit 11 (wrong length).
- R8: After fewer than four rejects in a row, `rx_word_o` keeps the last good data and `link_fault_o` stays 0.
- R9: The fourth reject in a row drives `rx_word_o` to 0 and `link_fault_o` to 1. Further rejects keep that state.
- R10: A valid frame clears the reject count and `link_fault_o`, and `rx_word_o` takes that frame's data.
- R11: If no frame completes within RX_TIMEOUT_CYCLES cycles (202 by default), that counts as one reject. A silent line therefore shuts the channels off after four timeouts, and not after three.
- R12: After reset, `rx_word_o` is 0, `link_fault_o` is 0 and `line_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_word_i | input | WIDTH | Enable word to send across the barrier |
| line_o | output | 1 | Serial line from the sending half |
| line_i | input | 1 | Serial line into the receiving half |
| rx_word_o | output | WIDTH | Channel enables on the far side |
| link_fault_o | output | 1 | High while the channels are forced off after repeated rejects |

## Verification
Some properties are checked by assertions on every cycle. A raised fault always comes with an all-zero output word. A good verdict always clears the fault. The output word stays unchanged in any cycle with no verdict and no timeout. An isolated reject leaves the word unchanged. On the sending side, assertions check that a pending change or an expired period starts a frame on the next edge, and that a frame is always followed by an idle cycle. Other behaviour can only be shown by the bench's scenarios: the exact bit layout and parity, the 178-cycle frame spacing, the alternating toggle, the 14-edge latency, the count of four consecutive rejects, and the silence timeout. The bench injects frames with a chosen defect in place of the looped-back line to drive these cases.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

    // Start marker (0 then 1) ahead of the data, toggle and parity after it.
    localparam int MARKER_BITS  = 2;
    localparam int TRAILER_BITS = 2;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_SETTLE = 2'd0,   // wait for the line to return idle
        RX_HUNT   = 2'd1,   // wait for the first marker bit
        RX_BITS   = 2'd2,   // second marker bit, then the payload
        RX_STOP   = 2'd3    // stop position, verdict
    } rx_state_e;

endpackage

// File: rtl/iso_link_tx.sv
module iso_link_tx
    import iso_link_pkg::*;
#(
    parameter int W      = 8,
    parameter int PERIOD = 178
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_i,
    output logic         line_o
);

    localparam int NBITS = MARKER_BITS + W + TRAILER_BITS;
    localparam int CW    = $clog2(NBITS);
    localparam int TW    = $clog2(PERIOD);
    localparam logic [CW-1:0] C_LAST = CW'(NBITS - 1);
    localparam logic [TW-1:0] T_LAST = TW'(PERIOD - 1);

    typedef struct packed {
        tx_state_e        state;
        logic [CW-1:0]    cnt;
        logic [NBITS-1:0] sh;
        logic [TW-1:0]    timer;
        logic [W-1:0]     last;
        logic             tog;
    } tx_regs_t;

    tx_regs_t q, d;
    logic     start;
    logic     new_tog;

    always_comb begin
        d       = q;
        start   = 1'b0;
        new_tog = ~q.tog;

        if (q.timer != T_LAST) begin
            d.timer = q.timer + 1'b1;
        end

        if (q.state == TX_SEND) begin
            d.sh = {1'b1, q.sh[NBITS-1:1]};
            if (q.cnt == C_LAST) begin
                d.state = TX_IDLE;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if ((q.timer == T_LAST) || (word_i != q.last)) begin
            start = 1'b1;
        end

        if (start) begin
            d.state = TX_SEND;
            d.cnt   = '0;
            d.sh    = {^{new_tog, word_i}, new_tog, word_i, 2'b10};
            d.last  = word_i;
            d.tog   = new_tog;
            d.timer = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign line_o = (q.state == TX_SEND) ? q.sh[0] : 1'b1;

    // A pending change while idle opens a frame on the next edge.
    assert_change_starts_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == TX_IDLE && word_i != q.last) |=> (q.state == TX_SEND && !line_o))
        else $error("change while idle did not start a frame");

    // An expired period opens a frame on the next edge.
    assert_period_starts_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == TX_IDLE && q.timer == T_LAST) |=> (q.state == TX_SEND))
        else $error("expired period did not start a frame");

    // The last bit of a frame is always followed by an idle line cycle.
    assert_idle_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == TX_SEND && q.cnt == C_LAST) |=> (line_o && q.state == TX_IDLE))
        else $error("no idle cycle after frame");

endmodule

// File: rtl/iso_link_rx.sv
module iso_link_rx
    import iso_link_pkg::*;
#(
    parameter int W       = 8,
    parameter int TIMEOUT = 202,
    parameter int LIMIT   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line_i,
    output logic [W-1:0] word_o,
    output logic         fault_o
);

    localparam int PB = W + TRAILER_BITS;       // payload bits after the marker
    localparam int CW = $clog2(PB + 1);
    localparam int TW = $clog2(TIMEOUT);
    localparam int RW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] C_LAST = CW'(PB);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);
    localparam logic [RW-1:0] R_MAX  = RW'(LIMIT);

    typedef struct packed {
        rx_state_e     state;
        logic [CW-1:0] cnt;
        logic          mark;
        logic [PB-1:0] sh;
        logic [TW-1:0] timer;
        logic [RW-1:0] rej;
        logic [W-1:0]  word;
        logic          fault;
    } rx_regs_t;

    rx_regs_t      q, d;
    logic          done;
    logic          ok;
    logic          tmo;
    logic          reject;
    logic [RW-1:0] rej_n;

    always_comb begin
        d      = q;
        done   = 1'b0;
        ok     = 1'b0;
        tmo    = 1'b0;
        rej_n  = q.rej;

        unique case (q.state)
            RX_SETTLE: begin
                if (line_i) d.state = RX_HUNT;
            end
            RX_HUNT: begin
                if (!line_i) begin
                    d.state = RX_BITS;
                    d.cnt   = '0;
                end
            end
            RX_BITS: begin
                if (q.cnt == '0) begin
                    d.mark = line_i;
                end else begin
                    d.sh = {line_i, q.sh[PB-1:1]};
                end
                if (q.cnt == C_LAST) begin
                    d.state = RX_STOP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                done    = 1'b1;
                ok      = q.mark & ~(^q.sh) & line_i;
                d.state = line_i ? RX_HUNT : RX_SETTLE;
            end
            default: d.state = RX_SETTLE;
        endcase

        if (done) begin
            d.timer = '0;
        end else if (q.timer == T_LAST) begin
            tmo     = 1'b1;
            d.timer = '0;
        end else begin
            d.timer = q.timer + 1'b1;
        end

        reject = (done & ~ok) | tmo;

        if (done && ok) begin
            d.rej   = '0;
            d.word  = q.sh[W-1:0];
            d.fault = 1'b0;
        end else if (reject) begin
            if (q.rej != R_MAX) rej_n = q.rej + 1'b1;
            d.rej = rej_n;
            if (rej_n == R_MAX) begin
                d.word  = '0;
                d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word_o  = q.word;
    assign fault_o = q.fault;

    assert_fault_forces_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.fault |-> (q.word == '0))
        else $error("fault raised with channels still enabled");

    assert_good_frame_restores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |=> (!q.fault && q.rej == '0))
        else $error("good frame did not clear the fault state");

    assert_hold_between_verdicts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !tmo) |=> $stable(q.word))
        else $error("output word moved without a verdict");

    assert_isolated_reject_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && q.rej < RW'(LIMIT - 1)) |=> ($stable(q.word) && !q.fault))
        else $error("isolated reject disturbed the outputs");

endmodule

// File: rtl/iso_link_framer.sv
module iso_link_framer #(
    parameter int WIDTH             = 8,
    parameter int PERIOD_CYCLES     = 178,
    parameter int RX_TIMEOUT_CYCLES = 202,
    parameter int REJECT_LIMIT      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] tx_word_i,
    output logic             line_o,
    input  logic             line_i,
    output logic [WIDTH-1:0] rx_word_o,
    output logic             link_fault_o
);

    iso_link_tx #(
        .W      (WIDTH),
        .PERIOD (PERIOD_CYCLES)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (tx_word_i),
        .line_o (line_o)
    );

    iso_link_rx #(
        .W       (WIDTH),
        .TIMEOUT (RX_TIMEOUT_CYCLES),
        .LIMIT   (REJECT_LIMIT)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_i),
        .word_o  (rx_word_o),
        .fault_o (link_fault_o)
    );

endmodule

// File: tb/iso_link_framer_test.sv
module iso_link_framer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       line_o;
    logic       line_i;
    logic [7:0] rx_word;
    logic       link_fault;
    logic       inj_line = 1'b1;
    logic       use_loop = 1'b1;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    assign line_i = use_loop ? line_o : inj_line;

    iso_link_framer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_word_i    (tx_word),
        .line_o       (line_o),
        .line_i       (line_i),
        .rx_word_o    (rx_word),
        .link_fault_o (link_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Caller stands at a negedge where line_o shows bit 0.
    task automatic capture_rest(output logic [11:0] f);
        f = '0;
        f[0] = line_o;
        for (int i = 1; i < 12; i++) begin
            @(negedge clk);
            f[i] = line_o;
        end
    endtask

    task automatic capture(output logic [11:0] f);
        do @(negedge clk); while (line_o !== 1'b0);
        capture_rest(f);
    endtask

    // kind: 0 good, 1 parity flipped, 2 marker bit 1 low, 3 stop position low
    task automatic send(input logic [7:0] data, input logic tog, input int kind);
        logic [11:0] b;
        b = {^{tog, data}, tog, data, 2'b10};
        if (kind == 1) b[11] = ~b[11];
        if (kind == 2) b[1] = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            inj_line = b[i];
        end
        @(negedge clk);
        inj_line = (kind == 3) ? 1'b0 : 1'b1;
        @(negedge clk);
        inj_line = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 rx_word after reset", rx_word, 8'h00);
        chk("R12 fault after reset", link_fault, 1'b0);
        chk("R12 line idle after reset", line_o, 1'b1);
    endtask

    task automatic t_write_latency;
        @(negedge clk);
        tx_word = 8'hA5;
        repeat (13) @(negedge clk);
        chk("R6 not earlier than 14 edges", rx_word, 8'h00);
        @(negedge clk);
        chk("R3 R6 write delivered at edge 14", rx_word, 8'hA5);
        chk("R6 no fault in loopback", link_fault, 1'b0);
    endtask

    task automatic t_period_format;
        logic [11:0] fa, fb;
        int n;
        capture(fa);
        n = 0;
        do begin @(negedge clk); n++; end while (line_o !== 1'b0);
        capture_rest(fb);
        chk("R1 marker", fa[1:0], 2'b10);
        chk("R1 data field", fa[9:2], 8'hA5);
        chk("R1 even parity", ^fa[11:2], 1'b0);
        chk("R1 even parity next", ^fb[11:2], 1'b0);
        chk("R2 frame spacing", n + 11, 178);
        chk("R4 toggle inverts", fa[10] ^ fb[10], 1'b1);
    endtask

    task automatic t_deferred_change;
        logic [11:0] f1, f2;
        int n;
        @(negedge clk);
        tx_word = 8'h3C;
        fork
            capture(f1);
            begin repeat (3) @(negedge clk); tx_word = 8'hC3; end
        join
        n = 0;
        do begin @(negedge clk); n++; end while (line_o !== 1'b0);
        capture_rest(f2);
        chk("R5 first frame intact", f1[9:2], 8'h3C);
        chk("R5 one idle cycle between frames", n - 1, 1);
        chk("R5 newer word follows", f2[9:2], 8'hC3);
        repeat (4) @(negedge clk);
        chk("R6 loopback holds newer word", rx_word, 8'hC3);
    endtask

    task automatic t_reject_kinds;
        send(8'h5A, 1'b0, 0);
        chk("R6 injected good frame", rx_word, 8'h5A);
        send(8'hFF, 1'b1, 1);
        chk("R7 parity reject", rx_word, 8'h5A);
        send(8'hFF, 1'b1, 2);
        chk("R7 marker reject", rx_word, 8'h5A);
        send(8'hFF, 1'b1, 3);
        chk("R7 length reject", rx_word, 8'h5A);
        chk("R8 three rejects no fault", link_fault, 1'b0);
    endtask

    task automatic t_shutdown_recover;
        send(8'hFF, 1'b0, 1);
        chk("R9 fourth reject clears word", rx_word, 8'h00);
        chk("R9 fourth reject raises fault", link_fault, 1'b1);
        send(8'hFF, 1'b0, 2);
        chk("R9 stays off on fifth reject", {link_fault, rx_word}, 9'h100);
        send(8'h81, 1'b1, 0);
        chk("R10 recovery word", rx_word, 8'h81);
        chk("R10 recovery clears fault", link_fault, 1'b0);
        send(8'hFF, 1'b0, 1);
        send(8'hFF, 1'b0, 3);
        send(8'hFF, 1'b0, 2);
        chk("R10 count restarted after good frame", {link_fault, rx_word}, 9'h081);
    endtask

    task automatic t_silence;
        send(8'h42, 1'b0, 0);
        chk("R6 good frame before silence", rx_word, 8'h42);
        repeat (700) @(negedge clk);
        chk("R11 three timeouts keep word", {link_fault, rx_word}, 9'h042);
        repeat (200) @(negedge clk);
        chk("R11 fourth timeout shuts off", {link_fault, rx_word}, 9'h100);
        send(8'h24, 1'b1, 0);
        chk("R10 R11 recovery after silence", {link_fault, rx_word}, 9'h024);
    endtask

    initial begin
        t_reset();
        t_write_latency();
        t_period_format();
        t_deferred_change();
        inj_line = 1'b1;
        use_loop = 1'b0;
        t_reject_kinds();
        t_shutdown_recover();
        t_silence();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule